// File: doc/BRIEF.md
# Vectored Interrupt Controller with Per-Source Auto-Mask

This block arbitrates between a set of interrupt and exception requests and tells the core which vector to enter. Each source has an enable bit in a mask register, and a global interrupt-enable flag gates the asynchronous sources. When a request is accepted, the controller emits a one-cycle pulse carrying the vector number and the address of that vector's slot in a handler-pointer table at a fixed base. The core then loads the handler pointer from that address. Saving processor state and running the handler are left to the core.

On acceptance the controller drops the global enable and clears the mask bit of the source it took. This keeps a level-held request from re-entering. Software turns the global enable back on with set and clear strobes. It restores a source by writing the whole mask word.

The low vectors are fixed. Vectors 0 and 2 to 5 are synchronous exceptions raised by the current instruction, so they ignore the global enable. Vector 1 is a non-maskable hardware error. Vector 6 and up (software interrupt and platform sources) need both their mask bit and the global enable.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `gie_o` is 0, `mask_o` is all ones (1 = source enabled), and `take_o` is 0.
- R2: A request on vector 6 or higher is accepted only when its mask bit is 1 and `gie_o` is 1, both as held before the sampling edge.
- R3: A request on vectors 0, 2, 3, 4 or 5 is accepted when its mask bit is 1, whatever the value of `gie_o`.
- R4: Vector 1 is accepted on a rising edge of its request (a 0-to-1 change between two sampling edges), whatever the mask and `gie_o`. Holding it high does not cause a second acceptance.
- R5: When several requests are eligible at the same edge, only the lowest-numbered one is accepted in that cycle.
- R6: An acceptance is shown in the cycle after the request is sampled. `take_o` is high for one cycle, `vec_o` is the vector number and `handler_addr_o` equals the table base plus 4 × vector.
- R7: An acceptance clears `gie_o`. This takes priority over a `gie_set_i` strobe in the same cycle.
- R8: An acceptance clears the mask bit of the accepted vector. This takes priority over a mask write to that bit in the same cycle; the other bits of that write still take effect.
- R9: A `mask_wr_i` strobe loads `mask_wdata_i` into the whole mask register at the next edge.
- R10: `gie_set_i` sets `gie_o` at the next edge and `gie_clr_i` clears it. If both strobes are high, clear wins.
- R11: Requests on maskable vectors are level-sensitive. A request still held after software restores its mask bit (and the global enable, where R2 applies) is accepted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Request lines, bit n is vector n |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | NUM_SRC | Mask write data, 1 = enabled |
| gie_set_i | input | 1 | Set global interrupt enable |
| gie_clr_i | input | 1 | Clear global interrupt enable |
| take_o | output | 1 | One-cycle acceptance pulse |
| vec_o | output | $clog2(NUM_SRC) | Accepted vector number |
| handler_addr_o | output | ADDR_W | Table slot address for the accepted vector |
| mask_o | output | NUM_SRC | Current mask register |
| gie_o | output | 1 | Current global interrupt enable |

## Verification
The bench builds the controller with 12 sources and a table base of 0x40. This keeps the fixed exception vectors and a handful of platform vectors, so every vector and every pair of vectors can be swept in a short run. Each vector is driven alone, under both global-enable settings and with only its own mask bit cleared. Every pair is driven together to check lowest-wins. Held levels, re-enable sequences and same-cycle collisions between acceptance and software writes are then run against a cycle model, followed by a pseudo-random stretch.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Fixed vector roles
  localparam int NMI_VEC       = 1;  // hardware error, bypasses mask and enable
  localparam int SYNC_LAST_VEC = 5;  // 0..5 come from the running instruction
  localparam int SWI_VEC       = 6;  // first vector gated by global enable
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               gie_i,
  input  logic               nmi_prev_i,
  output logic [NUM_SRC-1:0] elig_o
);
  import irq_pkg::*;

  // the hardware-error vector has no use for its mask bit
  logic unused_nmi_mask;
  assign unused_nmi_mask = mask_i[NMI_VEC];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (i == NMI_VEC) begin : g_nmi
      assign elig_o[i] = req_i[i] & ~nmi_prev_i;
    end else if (i <= SYNC_LAST_VEC) begin : g_sync
      assign elig_o[i] = req_i[i] & mask_i[i];
    end else begin : g_async
      assign elig_o[i] = req_i[i] & mask_i[i] & gie_i;
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = 5
) (
  input  logic [NUM_SRC-1:0] elig_i,
  output logic               any_o,
  output logic [VEC_W-1:0]   idx_o,
  output logic [NUM_SRC-1:0] grant_o
);
  // index: scan from the top so the lowest set bit is written last
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig_i[i]) idx_o = VEC_W'(i);
    end
  end

  assign any_o   = |elig_i;
  // isolate lowest set bit
  assign grant_o = elig_i & (~elig_i + NUM_SRC'(1));

  // R5
  always_comb begin
    if (any_o) begin
      lowest_grant_chk: assert (grant_o == (NUM_SRC'(1) << idx_o));
    end else begin
      idle_grant_chk: assert (grant_o == '0);
    end
  end
endmodule

// File: rtl/irq_state.sv
module irq_state #(
  parameter int                 NUM_SRC  = 32,
  parameter logic [NUM_SRC-1:0] MASK_RST = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mask_wr_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               acc_i,
  input  logic [NUM_SRC-1:0] grant_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               gie_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic               gie_q, gie_d;

  always_comb begin
    mask_d = mask_wr_i ? mask_wdata_i : mask_q;
    mask_d = mask_d & ~grant_i;
    gie_d  = gie_q;
    if (gie_set_i) gie_d = 1'b1;
    if (gie_clr_i) gie_d = 1'b0;
    if (acc_i)     gie_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= MASK_RST;
      gie_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      gie_q  <= gie_d;
    end
  end

  assign mask_o = mask_q;
  assign gie_o  = gie_q;

  // R9
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mask_wr_i)) |->
      ((mask_q & ~$past(grant_i)) == ($past(mask_wdata_i) & ~$past(grant_i))));
  // R8
  mask_autoclr_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_i)) |-> ((mask_q & $past(grant_i)) == '0));
  // R7
  gie_autoclr_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_i)) |-> !gie_q);
  // R10
  gie_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(gie_clr_i)) |-> !gie_q);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int                NUM_SRC    = 32,
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 'h0000_0100,
  parameter logic [NUM_SRC-1:0] MASK_RST  = '1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         req_i,
  input  logic                       mask_wr_i,
  input  logic [NUM_SRC-1:0]         mask_wdata_i,
  input  logic                       gie_set_i,
  input  logic                       gie_clr_i,
  output logic                       take_o,
  output logic [$clog2(NUM_SRC)-1:0] vec_o,
  output logic [ADDR_W-1:0]          handler_addr_o,
  output logic [NUM_SRC-1:0]         mask_o,
  output logic                       gie_o
);
  import irq_pkg::*;

  localparam int VEC_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] mask_q;
  logic               gie_q;
  logic               nmi_prev_q;
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] grant;
  logic               win_any;
  logic [VEC_W-1:0]   win_idx;

  logic               take_q;
  logic [VEC_W-1:0]   vec_q;
  logic [ADDR_W-1:0]  addr_q;

  irq_qualify #(.NUM_SRC(NUM_SRC)) u_qual (
    .req_i      (req_i),
    .mask_i     (mask_q),
    .gie_i      (gie_q),
    .nmi_prev_i (nmi_prev_q),
    .elig_o     (elig)
  );

  irq_prio #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_prio (
    .elig_i  (elig),
    .any_o   (win_any),
    .idx_o   (win_idx),
    .grant_o (grant)
  );

  irq_state #(.NUM_SRC(NUM_SRC), .MASK_RST(MASK_RST)) u_state (
    .clk          (clk),
    .rst          (rst),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .gie_set_i    (gie_set_i),
    .gie_clr_i    (gie_clr_i),
    .acc_i        (win_any),
    .grant_i      (grant),
    .mask_o       (mask_q),
    .gie_o        (gie_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_prev_q <= 1'b0;
      take_q     <= 1'b0;
      vec_q      <= '0;
      addr_q     <= '0;
    end else begin
      nmi_prev_q <= req_i[NMI_VEC];
      take_q     <= win_any;
      if (win_any) begin
        vec_q  <= win_idx;
        addr_q <= TABLE_BASE + (ADDR_W'(win_idx) << 2);
      end
    end
  end

  assign take_o         = take_q;
  assign vec_o          = vec_q;
  assign handler_addr_o = addr_q;
  assign mask_o         = mask_q;
  assign gie_o          = gie_q;

  // R7
  take_gie_low_chk: assert property (@(posedge clk) disable iff (rst)
    take_q |-> !gie_q);
  // R8
  take_mask_low_chk: assert property (@(posedge clk) disable iff (rst)
    (take_q && (int'(vec_q) != NMI_VEC)) |-> !mask_q[vec_q]);
  // R2
  async_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && take_q && (int'(vec_q) >= SWI_VEC)) |-> $past(gie_q));
  // R4
  nmi_once_chk: assert property (@(posedge clk) disable iff (rst)
    (take_q && (int'(vec_q) == NMI_VEC)) |=> !(take_q && (int'(vec_q) == NMI_VEC)));
  // R6
  slot_addr_chk: assert property (@(posedge clk) disable iff (rst)
    take_q |-> (addr_q == TABLE_BASE + (ADDR_W'(vec_q) << 2)));
endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam int          N          = 12;
  localparam int          AW         = 32;
  localparam logic [31:0] BASE       = 32'h0000_0040;
  localparam int          VW         = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic          mwr = 1'b0;
  logic [N-1:0]  mwd = '0;
  logic          gset = 1'b0;
  logic          gclr = 1'b0;
  logic          take;
  logic [VW-1:0] vec;
  logic [AW-1:0] addr;
  logic [N-1:0]  mask;
  logic          gie;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [N-1:0] m_mask;
  logic         m_gie;
  logic         m_prev1;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW), .TABLE_BASE(BASE)) u0 (
    .clk(clk), .rst(rst), .req_i(req), .mask_wr_i(mwr), .mask_wdata_i(mwd),
    .gie_set_i(gset), .gie_clr_i(gclr), .take_o(take), .vec_o(vec),
    .handler_addr_o(addr), .mask_o(mask), .gie_o(gie)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive, let the edge pass, compare against the model
  task automatic step(input logic [N-1:0] r, input logic wr, input logic [N-1:0] wd,
                      input logic s, input logic c, input string tag);
    logic [N-1:0] el;
    int           win;
    req = r; mwr = wr; mwd = wd; gset = s; gclr = c;
    el  = '0;
    for (int i = 0; i < N; i++) begin
      if (i == 1)      el[i] = r[i] & ~m_prev1;
      else if (i <= 5) el[i] = r[i] & m_mask[i];
      else             el[i] = r[i] & m_mask[i] & m_gie;
    end
    win = -1;
    for (int i = N - 1; i >= 0; i--) if (el[i]) win = i;
    if (wr) m_mask = wd;
    if (s)  m_gie = 1'b1;
    if (c)  m_gie = 1'b0;
    if (win >= 0) begin
      m_mask[win] = 1'b0;
      m_gie       = 1'b0;
    end
    m_prev1 = r[1];
    @(posedge clk);
    @(negedge clk);
    chk(take == (win >= 0), tag, "take", 32'(take), 32'(win >= 0));
    if (win >= 0) begin
      chk(int'(vec) == win, tag, "vec", 32'(vec), 32'(win));
      // R6 slot address
      chk(addr == BASE + 32'(win) * 4, "R6", "addr", addr, BASE + 32'(win) * 4);
    end
    chk(mask == m_mask, "R8 R9", "mask", 32'(mask), 32'(m_mask));
    chk(gie == m_gie, "R7 R10", "gie", 32'(gie), 32'(m_gie));
  endtask

  function automatic string cls(input int v);
    if (v == 1) return "R4";
    if (v <= 5) return "R3";
    return "R2";
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] ones;
    logic [31:0]  lfsr;
    ones = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_mask = ones; m_gie = 1'b0; m_prev1 = 1'b0;
    // R1 reset state
    chk(take == 1'b0, "R1", "take", 32'(take), 0);
    chk(gie == 1'b0, "R1", "gie", 32'(gie), 0);
    chk(mask == ones, "R1", "mask", 32'(mask), 32'(ones));

    // single-source sweep under both enable settings, then held level
    for (int g = 0; g < 2; g++) begin
      for (int v = 0; v < N; v++) begin
        step('0, 1'b1, ones, g[0], ~g[0], "R9 R10");
        step(N'(1) << v, 1'b0, '0, 1'b0, 1'b0, cls(v));
        step(N'(1) << v, 1'b0, '0, 1'b0, 1'b0, "R11 R4");
        step(N'(1) << v, 1'b0, '0, 1'b0, 1'b0, "R11 R4");
        step('0, 1'b0, '0, 1'b0, 1'b0, cls(v));
      end
    end

    // only the driven vector's mask bit cleared, enable on
    for (int v = 0; v < N; v++) begin
      step('0, 1'b1, ~(N'(1) << v), 1'b1, 1'b0, "R9");
      step(N'(1) << v, 1'b0, '0, 1'b0, 1'b0, cls(v));
      step('0, 1'b0, '0, 1'b0, 1'b0, cls(v));
    end

    // every pair: lowest wins
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        step('0, 1'b1, ones, 1'b1, 1'b0, "R9");
        step((N'(1) << a) | (N'(1) << b), 1'b0, '0, 1'b0, 1'b0, "R5");
        step('0, 1'b0, '0, 1'b0, 1'b0, "R5");
      end
    end

    // software re-enable of a held platform request
    step('0, 1'b1, ones, 1'b1, 1'b0, "R9");
    step(N'(1) << 8, 1'b0, '0, 1'b0, 1'b0, "R2");
    step(N'(1) << 8, 1'b0, '0, 1'b0, 1'b0, "R11");
    step(N'(1) << 8, 1'b1, ones, 1'b0, 1'b0, "R11");
    step(N'(1) << 8, 1'b0, '0, 1'b1, 1'b0, "R11");
    step(N'(1) << 8, 1'b0, '0, 1'b0, 1'b0, "R11");
    step('0, 1'b0, '0, 1'b0, 1'b0, "R11");

    // acceptance collides with a mask write and an enable set
    step('0, 1'b1, ones, 1'b1, 1'b0, "R9");
    step(N'(1) << 9, 1'b1, ones, 1'b1, 1'b0, "R7 R8");
    step('0, 1'b0, '0, 1'b0, 1'b0, "R8");
    // set and clear together
    step('0, 1'b0, '0, 1'b1, 1'b1, "R10");
    step('0, 1'b0, '0, 1'b1, 1'b0, "R10");
    step('0, 1'b0, '0, 1'b1, 1'b1, "R10");

    // pseudo-random stretch
    lfsr = 32'hACE1_2357;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(N'(lfsr[N-1:0] & lfsr[N+3:4]), lfsr[20] & lfsr[21],
           N'(lfsr[31:32-N]), lfsr[22] & lfsr[23], lfsr[24] & lfsr[25] & lfsr[26],
           "R5 R11");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule